// File: doc/BRIEF.md
# Externally Synchronised Sample Scheduler

This block decides when the battery-voltage terminator takes its next sample. Left alone, it issues a sample strobe on a long fixed period. When the charge-inhibit line carries short high pulses, the block locks to them instead. It then strobes once on the falling edge of each qualifying pulse, and it suppresses its own free-running strobes.

Every inhibit assertion is measured in ticks of an external timebase and sorted by width:
- **Short pulses** act as sync events.
- **Very long assertions** raise a one-cycle history-clear pulse so that the terminator can discard its stored samples.
- **Pulses in between** are ignored.
- **Pulses so narrow that no tick falls inside them** are discarded.

If sync pulses stop for longer than a window that depends on the charge-rate mode, the block drops its synchronised flag and returns to free-running.

The inhibit input is assumed to be already synchronised to the clock and free of glitches. The tick is a one-cycle enable, nominally every 10 µs. All limits are counted in ticks.

Top module: `ext_sync_sampler`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `sample_stb`, `hist_clr` and `synced` are all 0.
- R2: A high pulse on `inh` with a measured width of 1 to `SYNC_MAX_W` ticks is a sync pulse. Its width is the number of `tick` cycles sampled while `inh` is high. The cycle in which `inh` is first seen low after such a pulse is the cycle where the falling edge is detected. On the next clock edge, `sample_stb` goes high for one cycle and `synced` becomes 1.
- R3: A high pulse on `inh` that contains no tick produces no strobe and no clear.
- R4: A pulse wider than `SYNC_MAX_W` ticks that falls before reaching `CLR_MIN_W` ticks is ignored. It produces no strobe and no clear, and `synced` is left unchanged.
- R5: When `inh` stays high until its width reaches `CLR_MIN_W` ticks, `hist_clr` pulses for exactly one cycle during that assertion. No strobe is given when that assertion ends.
- R6: While `synced` is 0, `sample_stb` pulses once every `FREE_PER` ticks. The tick count restarts from reset and from the drop of `synced`.
- R7: While `synced` is 1, the only strobes are those caused by sync pulses.
- R8: The sync window is selected by `rate_sel`:
  - 2'b00 and 2'b01 select `WIN_LONG` ticks.
  - 2'b10 and 2'b11 select `WIN_SHORT` ticks.

  When that many ticks pass after the last sync pulse, `synced` falls. A sync pulse restarts the window. If `rate_sel` is changed to a window that has already expired, `synced` falls on the next tick. The first free-running strobe follows exactly `FREE_PER` ticks after the drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase enable |
| inh | input | 1 | Synchronised inhibit line, active high |
| rate_sel | input | 2 | Charge-rate mode; selects the sync window |
| sample_stb | output | 1 | One-cycle sample-start strobe |
| hist_clr | output | 1 | One-cycle voltage-history clear |
| synced | output | 1 | 1 while locked to external sync pulses |

## Verification
The hardest condition to reach from the ports is a pulse narrow enough to contain no tick. To hit it, the bench waits for the clock edge that carries a tick and raises `inh` just after that edge. It then lowers `inh` two cycles later, before the next tick arrives.

The second hard case is a window that expires because the mode changes. The bench locks in long-window mode, waits beyond the short window, and then switches `rate_sel`. The width-class checks run while the block is locked, so that no free-running strobe can hide a wrong one.

// File: rtl/ext_sync_pkg.sv
// Shared types for the external sample scheduler.
// Assumes: rate_sel is a plain two-bit code decoded only through this package.
package ext_sync_pkg;

    typedef enum logic [1:0] {
        RATE_HALF   = 2'b00,
        RATE_ONE    = 2'b01,
        RATE_TWO    = 2'b10,
        RATE_TWO_B  = 2'b11
    } rate_e;

    // True when the mode uses the short sync window (high-rate modes).
    function automatic logic rate_short_win(input logic [1:0] sel);
        rate_e r;
        r = rate_e'(sel);
        return (r == RATE_TWO) || (r == RATE_TWO_B);
    endfunction

endpackage

// File: rtl/ext_sync_width_cls.sv
// Measures every inhibit assertion in ticks and classifies it.
// sync_ev : combinational, in the cycle the fall is seen, for 1..SYNC_MAX_W ticks.
// clr_ev  : combinational, in the tick cycle in which the width reaches CLR_MIN_W.
// Assumes: inh is synchronous and glitch free; SYNC_MAX_W < CLR_MIN_W.
module ext_sync_width_cls #(
    parameter int SYNC_MAX_W = 350,
    parameter int CLR_MIN_W  = 1200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic inh,
    output logic sync_ev,
    output logic clr_ev
);
    localparam int WW = $clog2(CLR_MIN_W + 1);
    localparam logic [WW-1:0] SYNC_LIM = WW'(SYNC_MAX_W);
    localparam logic [WW-1:0] CLR_LIM  = WW'(CLR_MIN_W);
    localparam logic [WW-1:0] CLR_PRE  = WW'(CLR_MIN_W - 1);

    logic          inh_q;
    logic [WW-1:0] width_q;

    // Previous inhibit level, used for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) inh_q <= 1'b0;
        else        inh_q <= inh;
    end

    // Width counter: clears while low, counts ticks while high, saturates at CLR_MIN_W.
    always_ff @(posedge clk) begin
        if (!rst_n)                          width_q <= '0;
        else if (!inh)                       width_q <= '0;
        else if (tick && width_q != CLR_LIM) width_q <= width_q + 1'b1;
    end

    // Width classification at the fall, and the clear when the long threshold is reached.
    always_comb begin
        sync_ev = inh_q && !inh && (width_q != '0) && (width_q <= SYNC_LIM);
        clr_ev  = inh && tick && (width_q == CLR_PRE);
    end

endmodule

// File: rtl/ext_sync_tracker.sv
// Holds the synchronised flag and the mode-dependent sync window.
// A sync event sets the flag and restarts the window. The flag drops on the tick
// that completes the window. The comparison is >= so that a switch to a shorter
// window drops the flag at once. Sync events take priority over a drop.
module ext_sync_tracker #(
    parameter int WIN_LONG  = 1870000,
    parameter int WIN_SHORT = 940000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sync_ev,
    input  logic [1:0] rate_sel,
    output logic       synced
);
    import ext_sync_pkg::*;

    localparam int WMAX = (WIN_LONG > WIN_SHORT) ? WIN_LONG : WIN_SHORT;
    localparam int WCW  = $clog2(WMAX + 1);
    localparam logic [WCW-1:0] LONG_LAST  = WCW'(WIN_LONG - 1);
    localparam logic [WCW-1:0] SHORT_LAST = WCW'(WIN_SHORT - 1);

    logic [WCW-1:0] win_q;
    logic [WCW-1:0] win_last;

    // Last window count for the current mode.
    always_comb win_last = rate_short_win(rate_sel) ? SHORT_LAST : LONG_LAST;

    // Window timer and synchronised flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced <= 1'b0;
            win_q  <= '0;
        end else if (sync_ev) begin
            synced <= 1'b1;
            win_q  <= '0;
        end else if (synced && tick) begin
            if (win_q >= win_last) begin
                synced <= 1'b0;
                win_q  <= '0;
            end else begin
                win_q  <= win_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ext_sync_free_timer.sv
// Free-running sample period counter.
// Held at zero while hold is high (locked or sync in progress). Otherwise it
// fires free_ev on every FREE_PER-th tick.
module ext_sync_free_timer #(
    parameter int FREE_PER = 1700000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    output logic free_ev
);
    localparam int FW = $clog2(FREE_PER + 1);
    localparam logic [FW-1:0] LAST = FW'(FREE_PER - 1);

    logic [FW-1:0] cnt_q;

    // Fire on the last tick of the period when not held.
    always_comb free_ev = !hold && tick && (cnt_q == LAST);

    // Period counter with wrap and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (hold) cnt_q <= '0;
        else if (tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/ext_sync_sampler.sv
// Top of the sample scheduler.
// Combines inhibit-width classification, sync tracking and the free-running
// period into a registered sample strobe, history clear and lock flag.
// All limits are counted in tick units. Assumes inh is synchronous.
module ext_sync_sampler #(
    parameter int SYNC_MAX_W = 350,
    parameter int CLR_MIN_W  = 1200,
    parameter int WIN_LONG   = 1870000,
    parameter int WIN_SHORT  = 940000,
    parameter int FREE_PER   = 1700000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       inh,
    input  logic [1:0] rate_sel,
    output logic       sample_stb,
    output logic       hist_clr,
    output logic       synced
);
    logic sync_ev;
    logic clr_ev;
    logic free_ev;
    logic free_hold;

    ext_sync_width_cls #(
        .SYNC_MAX_W (SYNC_MAX_W),
        .CLR_MIN_W  (CLR_MIN_W)
    ) u_cls (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .inh     (inh),
        .sync_ev (sync_ev),
        .clr_ev  (clr_ev)
    );

    ext_sync_tracker #(
        .WIN_LONG  (WIN_LONG),
        .WIN_SHORT (WIN_SHORT)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sync_ev  (sync_ev),
        .rate_sel (rate_sel),
        .synced   (synced)
    );

    // Free timer is held while locked or while a sync event restarts the lock.
    always_comb free_hold = synced || sync_ev;

    ext_sync_free_timer #(
        .FREE_PER (FREE_PER)
    ) u_free (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .hold    (free_hold),
        .free_ev (free_ev)
    );

    // Registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            hist_clr   <= 1'b0;
        end else begin
            sample_stb <= sync_ev || free_ev;
            hist_clr   <= clr_ev;
        end
    end

endmodule

// File: rtl/ext_sync_sampler_chk.sv
// Port-level properties of the sample scheduler, bound to every instance.
module ext_sync_sampler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       inh,
    input logic [1:0] rate_sel,
    input logic       sample_stb,
    input logic       hist_clr,
    input logic       synced
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sample_stb && !hist_clr && !synced));

    // R2
    lock_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> sample_stb);

    // R7
    locked_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && $past(synced)) |-> (!$past(inh) && $past(inh, 2)));

    // R5
    clr_during_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hist_clr |-> $past(inh));

    // R5
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hist_clr |=> !hist_clr);

    // R8
    unlock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(synced) |-> !sample_stb);

    // R8
    unlock_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(synced) |-> $past(tick));

endmodule

bind ext_sync_sampler ext_sync_sampler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .inh        (inh),
    .rate_sel   (rate_sel),
    .sample_stb (sample_stb),
    .hist_clr   (hist_clr),
    .synced     (synced)
);

// File: tb/ext_sync_sampler_test.sv
// Directed bench for the sample scheduler, with reduced tick limits.
module ext_sync_sampler_test;
    localparam int TP    = 4;    // clock cycles per tick
    localparam int SMAX  = 5;
    localparam int CMIN  = 20;
    localparam int WLONG = 400;
    localparam int WSHRT = 200;
    localparam int FPER  = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       inh = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       sample_stb, hist_clr, synced;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, tcnt = 0;
    int stb_cnt = 0, clr_cnt = 0, fall_cnt = 0;
    int last_stb = 0, last_fall = 0;
    logic prev_sync = 1'b0;
    bit   done = 1'b0;

    ext_sync_sampler #(
        .SYNC_MAX_W (SMAX), .CLR_MIN_W (CMIN), .WIN_LONG (WLONG),
        .WIN_SHORT (WSHRT), .FREE_PER (FPER)
    ) uut (
        .clk (clk), .rst_n (rst_n), .tick (tick), .inh (inh), .rate_sel (rate_sel),
        .sample_stb (sample_stb), .hist_clr (hist_clr), .synced (synced)
    );

    always #4 clk = ~clk;

    // Tick generator: high for one cycle out of every TP.
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % TP;
        tick = (tcnt == 0);
    end

    // Event monitor, sampling away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sample_stb) begin stb_cnt = stb_cnt + 1; last_stb = cyc; end
        if (hist_clr) clr_cnt = clr_cnt + 1;
        if (prev_sync && !synced) begin fall_cnt = fall_cnt + 1; last_fall = cyc; end
        prev_sync = synced;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(input int cycles);
        @(negedge clk); inh = 1'b1;
        repeat (cycles) @(negedge clk);
        inh = 1'b0;
    endtask

    task automatic wait_stb();
        int c0 = stb_cnt;
        while (stb_cnt == c0) @(negedge clk);
        #1;
    endtask

    task automatic wait_fall();
        int c0 = fall_cnt;
        while (fall_cnt == c0) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk(sample_stb == 0, "R1", "stb in reset", sample_stb, 0);
        chk(hist_clr == 0, "R1", "clr in reset", hist_clr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(synced == 0, "R1", "synced after reset", synced, 0);
    endtask

    task automatic t_free();
        int a;
        wait_stb(); a = last_stb;
        wait_stb();
        chk(last_stb - a == FPER * TP, "R6", "free interval 1", last_stb - a, FPER * TP);
        a = last_stb;
        wait_stb();
        chk(last_stb - a == FPER * TP, "R6", "free interval 2", last_stb - a, FPER * TP);
    endtask

    task automatic t_sync_lock();
        int c0;
        rate_sel = 2'b00;
        pulse(3 * TP);
        @(negedge clk);
        chk(sample_stb == 1, "R2", "strobe after sync fall", sample_stb, 1);
        chk(synced == 1, "R2", "synced after sync", synced, 1);
        #1; c0 = stb_cnt;
        for (int i = 0; i < 3; i++) begin
            repeat (900) @(negedge clk);
            pulse(3 * TP);
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        #1;
        chk(stb_cnt - c0 == 3, "R7", "strobes while locked", stb_cnt - c0, 3);
        chk(synced == 1, "R7", "still locked", synced, 1);
    endtask

    task automatic t_widths();
        int c0, k0;
        pulse(3 * TP);
        repeat (3) @(negedge clk);
        #1; c0 = stb_cnt; k0 = clr_cnt;
        // R3: narrow pulse placed between two ticks
        do @(posedge clk); while (!tick);
        @(negedge clk); inh = 1'b1;
        repeat (2) @(negedge clk); inh = 1'b0;
        repeat (6) @(negedge clk); #1;
        chk(stb_cnt == c0, "R3", "narrow pulse strobes", stb_cnt - c0, 0);
        // R4: width between the sync and clear limits
        pulse(10 * TP);
        repeat (6) @(negedge clk); #1;
        chk(stb_cnt == c0, "R4", "gap pulse strobes", stb_cnt - c0, 0);
        chk(clr_cnt == k0, "R4", "gap pulse clears", clr_cnt - k0, 0);
        chk(synced == 1, "R4", "gap pulse keeps lock", synced, 1);
        // R5: long assertion
        pulse(30 * TP);
        repeat (6) @(negedge clk); #1;
        chk(clr_cnt - k0 == 1, "R5", "long pulse clears", clr_cnt - k0, 1);
        chk(stb_cnt == c0, "R5", "long pulse strobes", stb_cnt - c0, 0);
    endtask

    task automatic t_timeout(input logic [1:0] sel, input int win);
        int d;
        rate_sel = sel;
        pulse(3 * TP);
        wait_fall();
        d = last_fall - last_stb;
        chk(d >= TP * (win - 1) + 1 && d <= TP * win, "R8", "window length", d, TP * win);
        wait_stb();
        chk(last_stb - last_fall == FPER * TP, "R8", "first free strobe after drop",
            last_stb - last_fall, FPER * TP);
    endtask

    task automatic t_switch();
        rate_sel = 2'b00;
        pulse(3 * TP);
        repeat (1000) @(negedge clk);
        chk(synced == 1, "R8", "long window still locked", synced, 1);
        rate_sel = 2'b10;
        repeat (2 * TP) @(negedge clk);
        chk(synced == 0, "R8", "switch to short window drops", synced, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_free();
        t_sync_lock();
        t_widths();
        t_timeout(2'b00, WLONG);
        t_timeout(2'b01, WLONG);
        t_timeout(2'b10, WSHRT);
        t_timeout(2'b11, WSHRT);
        t_switch();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

endmodule